// File: doc/BRIEF.md
# Memory Fault Capture Unit

This block sits next to a memory controller and records access faults that the request path reports. A fault arrives as a one-cycle pulse carrying a cause index, an error type, the requesting client's ID, a read/write flag, a secure flag, three page permission flags and a physical address of up to 34 bits. Each recognised cause sets its own bit in a sticky cause register. The details of the first fault since the cause register was last empty are frozen into an error word and an error address register.

Software reaches the block through a plain register port with a combinational read path and a single-cycle write strobe. It clears cause bits by writing ones to them, and selects which causes raise the level interrupt through an enable register. The interrupt is high while any pending cause is also enabled.

Top module: `errcap_unit`

## Requirements
- R1: Registers decode on the full offset: pending causes at 0x00, cause enables at 0x04, error word at 0x08, error address bits 31:0 at 0x0C. Any other offset reads zero, and writes to it change nothing. The error word and error address are read-only.
- R2: A fault pulse whose cause index is one of 6, 8, 9, 10, 11, 12, 13 or 16 sets pending bit [index] on the next clock edge. Any other index is ignored: it sets no bit and captures nothing. Pending bits outside that set always read 0.
- R3: A write to 0x00 clears every pending bit written as 1 and leaves bits written as 0 unchanged.
- R4: When a fault sets a pending bit in the same cycle that a write clears that bit, the bit ends up set.
- R5: Only enable bits for the recognised causes can be stored; the others read 0. `irq` is high exactly when some pending bit and its enable bit are both 1. It follows the registers with no extra delay.
- R6: A recognised fault that arrives while all pending bits are 0 loads the error word as follows. Bits 30:28 hold the type (2 decode, 3 trust-zone, 4 carveout, 6 translation). Bit 17 is the secure flag. Bit 16 is 1 for a write and 0 for a read. Bits CLIENT_W-1:0 hold the client ID. All other bits are 0 unless R7 or R8 sets them.
- R7: Error word bits 27, 26 and 25 hold the page readable, writable and non-secure flags only when the type is 6. For any other type they are 0.
- R8: On capture, address bits 31:0 go to the error address register, and address bits 33:32 go to error word bits 21:20.
- R9: A recognised fault that arrives while any pending bit is 1 only sets its pending bit. The error word and error address keep the earlier fault until all pending bits are cleared.
- R10: After reset, the pending bits, enable bits, error word, error address and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| faultValid | input | 1 | One-cycle fault pulse |
| faultCause | input | 5 | Cause index (pending bit position) |
| faultType | input | 3 | Error type code |
| faultClient | input | CLIENT_W | Requesting client ID |
| faultWrite | input | 1 | 1 for a write access, 0 for a read |
| faultSecure | input | 1 | Access was secure |
| faultPermRd | input | 1 | Page was readable |
| faultPermWr | input | 1 | Page was writable |
| faultPermNs | input | 1 | Page was non-secure |
| faultAddr | input | PHYS_W | Faulting physical address |
| regAddr | input | REG_AW | Register byte offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 7-bit client ID, a full 34-bit address and an 8-bit offset. With these values the upper address bits land in the error word, and the client field leaves zero bits above it that the bench can check. An 8-bit offset also lets the bench reach the misaligned and out-of-map offsets 0x01, 0x10 and 0xFC. Random faults use all 32 cause indices, so ignored indices occur often. Frequent write-all-ones clears keep the unit moving between the empty state, where it captures, and the locked state, where it does not.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int CAUSE_W = 5;
  localparam logic [31:0] CAUSE_MAP = 32'h0001_3F40;
  localparam int OFS_PEND = 'h00;
  localparam int OFS_ENAB = 'h04;
  localparam int OFS_EWORD = 'h08;
  localparam int OFS_EADDR = 'h0C;
  localparam logic [2:0] TYPE_XLATE = 3'd6;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ENAB,
    SEL_EWORD,
    SEL_EADDR
  } rdSel_e;

  typedef struct packed {
    logic [31:0] setVec;
    logic [31:0] clrVec;
    logic        enabWe;
    logic        capture;
    rdSel_e      rdSel;
  } strobes_t;
endpackage

// File: rtl/errcap_ctrl.sv
module errcap_ctrl
  import errcap_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic               faultValid,
  input  logic [CAUSE_W-1:0] faultCause,
  input  logic               pendAny,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output strobes_t           stb
);
  logic hitPend, hitEnab, hitEword, hitEaddr;
  logic causeKnown;

  always_comb begin
    hitPend  = (regAddr == REG_AW'(OFS_PEND));
    hitEnab  = (regAddr == REG_AW'(OFS_ENAB));
    hitEword = (regAddr == REG_AW'(OFS_EWORD));
    hitEaddr = (regAddr == REG_AW'(OFS_EADDR));
    causeKnown = CAUSE_MAP[faultCause];

    stb.setVec  = (faultValid && causeKnown) ? (32'(1) << faultCause) : 32'd0;
    stb.clrVec  = (regWrEn && hitPend) ? regWrData : 32'd0;
    stb.enabWe  = regWrEn && hitEnab;
    stb.capture = faultValid && causeKnown && !pendAny;

    if (hitPend)       stb.rdSel = SEL_PEND;
    else if (hitEnab)  stb.rdSel = SEL_ENAB;
    else if (hitEword) stb.rdSel = SEL_EWORD;
    else if (hitEaddr) stb.rdSel = SEL_EADDR;
    else               stb.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/errcap_datapath.sv
module errcap_datapath
  import errcap_pkg::*;
#(
  parameter int CLIENT_W = 7,
  parameter int PHYS_W   = 34
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            stb,
  input  logic [2:0]          faultType,
  input  logic [CLIENT_W-1:0] faultClient,
  input  logic                faultWrite,
  input  logic                faultSecure,
  input  logic                faultPermRd,
  input  logic                faultPermWr,
  input  logic                faultPermNs,
  input  logic [PHYS_W-1:0]   faultAddr,
  input  logic [31:0]         regWrData,
  output logic                pendAny,
  output logic [31:0]         regRdData,
  output logic                irq
);
  localparam int HI_W = PHYS_W - 32;

  logic [31:0] pendQ, enabQ, ewordQ, eaddrQ;
  logic [31:0] capWord;
  logic [1:0]  addrHi;
  logic [2:0]  permBits;

  generate
    if (HI_W > 0) begin : g_hi
      assign addrHi = 2'(faultAddr[PHYS_W-1:32]);
    end else begin : g_nohi
      assign addrHi = 2'b00;
    end
  endgenerate

  always_comb begin
    permBits = (faultType == TYPE_XLATE) ? {faultPermRd, faultPermWr, faultPermNs} : 3'b000;
    capWord = {1'b0, faultType, permBits, 3'b000, addrHi, 2'b00,
               faultSecure, faultWrite, 16'(faultClient)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ  <= '0;
      enabQ  <= '0;
      ewordQ <= '0;
      eaddrQ <= '0;
    end else begin
      pendQ <= ((pendQ & ~stb.clrVec) | stb.setVec) & CAUSE_MAP;
      if (stb.enabWe) enabQ <= regWrData & CAUSE_MAP;
      if (stb.capture) begin
        ewordQ <= capWord;
        eaddrQ <= faultAddr[31:0];
      end
    end
  end

  always_comb begin
    pendAny = |pendQ;
    irq     = |(pendQ & enabQ);
    case (stb.rdSel)
      SEL_PEND:  regRdData = pendQ;
      SEL_ENAB:  regRdData = enabQ;
      SEL_EWORD: regRdData = ewordQ;
      SEL_EADDR: regRdData = eaddrQ;
      default:   regRdData = 32'd0;
    endcase
  end

  // R2 / R4: a recognised fault always leaves its bit set, clear or not
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setVec != 32'd0) |=> ((pendQ & $past(stb.setVec)) == $past(stb.setVec)));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~CAUSE_MAP) == 32'd0));

  a_r9_hold_details: assert property (@(posedge clk) disable iff (!rstN)
    (|pendQ) |=> ($stable(ewordQ) && $stable(eaddrQ)));

  a_r7_perm_gated: assert property (@(posedge clk) disable iff (!rstN)
    (ewordQ[30:28] != TYPE_XLATE) |-> (ewordQ[27:25] == 3'b000));

  a_r5_irq_drop_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past((stb.clrVec != 32'd0) || stb.enabWe));
endmodule

// File: rtl/errcap_unit.sv
module errcap_unit
  import errcap_pkg::*;
#(
  parameter int CLIENT_W = 7,
  parameter int PHYS_W   = 34,
  parameter int REG_AW   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                faultValid,
  input  logic [CAUSE_W-1:0]  faultCause,
  input  logic [2:0]          faultType,
  input  logic [CLIENT_W-1:0] faultClient,
  input  logic                faultWrite,
  input  logic                faultSecure,
  input  logic                faultPermRd,
  input  logic                faultPermWr,
  input  logic                faultPermNs,
  input  logic [PHYS_W-1:0]   faultAddr,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic                regWrEn,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic                irq
);
  strobes_t stb;
  logic     pendAny;

  errcap_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .faultValid(faultValid),
    .faultCause(faultCause),
    .pendAny(pendAny),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .regWrData(regWrData),
    .stb(stb)
  );

  errcap_datapath #(.CLIENT_W(CLIENT_W), .PHYS_W(PHYS_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .stb(stb),
    .faultType(faultType),
    .faultClient(faultClient),
    .faultWrite(faultWrite),
    .faultSecure(faultSecure),
    .faultPermRd(faultPermRd),
    .faultPermWr(faultPermWr),
    .faultPermNs(faultPermNs),
    .faultAddr(faultAddr),
    .regWrData(regWrData),
    .pendAny(pendAny),
    .regRdData(regRdData),
    .irq(irq)
  );
endmodule

// File: tb/tb_errcap_unit.sv
module tb_errcap_unit;
  localparam int PERIOD   = 20;
  localparam int CLIENT_W = 7;
  localparam int PHYS_W   = 34;
  localparam int REG_AW   = 8;
  localparam logic [31:0] KNOWN = 32'h0001_3F40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultValid = 1'b0;
  logic [4:0] faultCause = '0;
  logic [2:0] faultType = '0;
  logic [CLIENT_W-1:0] faultClient = '0;
  logic faultWrite = 1'b0, faultSecure = 1'b0;
  logic faultPermRd = 1'b0, faultPermWr = 1'b0, faultPermNs = 1'b0;
  logic [PHYS_W-1:0] faultAddr = '0;
  logic [REG_AW-1:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irq;

  int checks = 0;
  int fails = 0;
  logic [31:0] mPend = '0, mEnab = '0, mWord = '0, mAddr = '0;

  errcap_unit #(.CLIENT_W(CLIENT_W), .PHYS_W(PHYS_W), .REG_AW(REG_AW)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input logic [2:0] t, input logic [CLIENT_W-1:0] c,
      input logic w, input logic s, input logic pr, input logic pw, input logic pn,
      input logic [PHYS_W-1:0] a);
    logic [2:0] p;
    p = (t == 3'd6) ? {pr, pw, pn} : 3'b000;
    return {1'b0, t, p, 3'b000, a[33:32], 2'b00, s, w, 16'(c)};
  endfunction

  task automatic readReg(input logic [REG_AW-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic checkAll();
    logic [31:0] d;
    readReg(8'h00, d); chk("R3 pending", d, mPend);
    readReg(8'h04, d); chk("R5 enable", d, mEnab);
    readReg(8'h08, d); chk("R6 error word", d, mWord);
    readReg(8'h0C, d); chk("R8 error address", d, mAddr);
    readReg(8'h10, d); chk("R1 unmapped offset", d, 32'd0);
    chk("R5 irq", {31'd0, irq}, {31'd0, |(mPend & mEnab)});
  endtask

  task automatic cycle(input logic v, input logic [4:0] cause, input logic [2:0] t,
      input logic [CLIENT_W-1:0] c, input logic w, input logic s, input logic pr,
      input logic pw, input logic pn, input logic [PHYS_W-1:0] a,
      input logic we, input logic [REG_AW-1:0] ra, input logic [31:0] wd);
    logic [31:0] setv, clrv;
    @(negedge clk);
    faultValid = v; faultCause = cause; faultType = t; faultClient = c;
    faultWrite = w; faultSecure = s; faultPermRd = pr; faultPermWr = pw;
    faultPermNs = pn; faultAddr = a; regWrEn = we; regAddr = ra; regWrData = wd;
    @(posedge clk);
    setv = v ? ((32'd1 << cause) & KNOWN) : 32'd0;
    clrv = (we && ra == 8'h00) ? wd : 32'd0;
    if (setv != 0 && mPend == 0) begin
      mWord = expWord(t, c, w, s, pr, pw, pn, a);
      mAddr = a[31:0];
    end
    mPend = ((mPend & ~clrv) | setv) & KNOWN;
    if (we && ra == 8'h04) mEnab = wd & KNOWN;
    #1;
    faultValid = 1'b0;
    regWrEn = 1'b0;
    checkAll();
  endtask

  task automatic idleWrite(input logic [REG_AW-1:0] ra, input logic [31:0] wd);
    cycle(1'b0, 5'd0, 3'd0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b1, ra, wd);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(7331));
    #(PERIOD * 3);
    // R10: reset state
    readReg(8'h00, d); chk("R10 pending at reset", d, 32'd0);
    readReg(8'h04, d); chk("R10 enable at reset", d, 32'd0);
    readReg(8'h08, d); chk("R10 error word at reset", d, 32'd0);
    readReg(8'h0C, d); chk("R10 error address at reset", d, 32'd0);
    chk("R10 irq at reset", {31'd0, irq}, 32'd0);
    rstN = 1'b1;

    // R5: only recognised enables stick
    idleWrite(8'h04, 32'hFFFF_FFFF);
    readReg(8'h04, d); chk("R5 enable mask", d, 32'h0001_3F40);
    // R2: unrecognised cause 7 ignored
    cycle(1'b1, 5'd7, 3'd6, 7'h11, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 34'h1_0000_0004, 1'b0, 8'h00, 0);
    readReg(8'h08, d); chk("R2 ignored cause captures nothing", d, 32'd0);
    readReg(8'h00, d); chk("R2 ignored cause sets nothing", d, 32'd0);
    // R6 R7 R8: capture of a translation fault
    cycle(1'b1, 5'd10, 3'd6, 7'h55, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 34'h3_1234_5678, 1'b0, 8'h00, 0);
    readReg(8'h08, d); chk("R7 perm captured type 6", d, 32'h6A33_0055);
    readReg(8'h0C, d); chk("R8 low address", d, 32'h1234_5678);
    chk("R5 irq high", {31'd0, irq}, 32'd1);
    // R9: second fault only sets its bit
    cycle(1'b1, 5'd6, 3'd2, 7'h03, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 34'h0_0000_0100, 1'b0, 8'h00, 0);
    readReg(8'h08, d); chk("R9 word held", d, 32'h6A33_0055);
    readReg(8'h00, d); chk("R9 both pending", d, 32'h0000_0440);
    // R3: zero write no effect, one clears
    idleWrite(8'h00, 32'd0);
    readReg(8'h00, d); chk("R3 zero write", d, 32'h0000_0440);
    idleWrite(8'h00, 32'h0000_0400);
    readReg(8'h00, d); chk("R3 one clears", d, 32'h0000_0040);
    // R4: set and clear of bit 6 in the same cycle
    cycle(1'b1, 5'd6, 3'd4, 7'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 34'h0, 1'b1, 8'h00, 32'h0000_0040);
    readReg(8'h00, d); chk("R4 set wins", d, 32'h0000_0040);
    // R1: writes to read-only and unmapped offsets
    idleWrite(8'h08, 32'hFFFF_FFFF);
    idleWrite(8'h0C, 32'hFFFF_FFFF);
    idleWrite(8'h10, 32'hFFFF_FFFF);
    idleWrite(8'h01, 32'hFFFF_FFFF);
    readReg(8'h08, d); chk("R1 error word read-only", d, 32'h6A33_0055);
    readReg(8'hFC, d); chk("R1 unmapped high offset", d, 32'd0);
    readReg(8'h01, d); chk("R1 misaligned offset", d, 32'd0);
    idleWrite(8'h00, 32'hFFFF_FFFF);
    chk("R5 irq low after clear", {31'd0, irq}, 32'd0);
    // R7: non-translation type hides perms
    cycle(1'b1, 5'd16, 3'd3, 7'h7F, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 34'h2_ABCD_0000, 1'b0, 8'h00, 0);
    readReg(8'h08, d); chk("R7 perm zero type 3", d, 32'h3022_007F);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      logic [REG_AW-1:0] ra;
      logic [31:0] wd;
      r = $urandom;
      case (r[3:1])
        3'd0, 3'd1: ra = 8'h00;
        3'd2: ra = 8'h04;
        3'd3: ra = 8'h08;
        3'd4: ra = 8'h0C;
        default: ra = 8'(($urandom % 64) * 4);
      endcase
      wd = (r[5:4] == 2'b00) ? 32'hFFFF_FFFF : $urandom;
      cycle(r[8], 5'($urandom), (r[9] ? 3'd6 : 3'($urandom)), CLIENT_W'($urandom),
            r[10], r[11], r[12], r[13], r[14], {2'($urandom), 32'($urandom)},
            (r[17:15] < 3'd3), ra, wd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule